// File: doc/BRIEF.md
# Core Register Window Access Fault Checker

This block sits on the core's data path in front of the bus that carries accesses to the core control registers. These registers live in a 2 MB window at 0xFFE00000. Every load or store request is classified before it reaches that bus.

An address in the window is legal only when three conditions hold, checked in order. The reserved field (address bits 19:16) must be zero. The peripheral index (bits 15:12) must name an implemented peripheral. The register offset (bits 11:0) must lie strictly below that peripheral's parameterised limit.

An illegal access is dropped and raises a one-cycle protection exception that carries cause value 0x2E. The same fault records two things: the full data address in a fault-address register, and the PC of the offending instruction in a return-from-exception register. Software may overwrite the fault-address register, for example to clear it before a test. Legal accesses, and any address outside the window, are forwarded to the register bus one cycle later.

Top module: `mmr_fault_chk`

## Requirements
- R1: A request whose address is in the window with any of bits 19:16 set faults, and exc_kind reports 1 (reserved field). This takes priority over every other fault kind.
- R2: A request in the window with bits 19:16 zero and bits 15:12 greater than or equal to NUM_PERIPH (default 9) faults, and exc_kind reports 2 (peripheral index).
- R3: A request in the window with a valid peripheral index and offset bits 11:0 at or above that peripheral's limit faults, and exc_kind reports 3 (offset). Offsets strictly below the limit are legal, and exc_kind then reads 0. The default limits for peripherals 0 to 8 are 0x400, 0x400, 0x114, 0x010, 0x008, 0x010, 0x104, 0x204 and 0x108.
- R4: exc_pulse is high for exactly the one cycle after a faulting request's clock edge. On that fault, exc_cause is loaded with 0x2E and exc_supv with the request's supervisor flag.
- R5: On a fault, fault_addr is loaded with the full 32-bit request address.
- R6: On a fault, ret_pc is loaded with the PC presented with the faulting request.
- R7: A faulting access is suppressed: bus_wr and bus_rd stay low in the cycle exc_pulse is high. A legal request drives bus_wr (store) or bus_rd (load) and bus_addr one cycle after the request.
- R8: Addresses below 0xFFE00000 are never checked. They are forwarded like legal accesses and never fault.
- R9: fault_addr, ret_pc, exc_cause and exc_supv hold their values in any cycle without a fault, except that a software write loads fault_addr.
- R10: sw_fa_we loads sw_fa_data into fault_addr on the next edge. If a fault arrives on the same edge, the fault address wins.
- R11: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Data access request valid |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Data address of the access |
| req_pc | input | 32 | PC of the issuing instruction |
| req_supv | input | 1 | Request made in supervisor mode |
| sw_fa_we | input | 1 | Software write strobe for the fault-address register |
| sw_fa_data | input | 32 | Software write data for the fault-address register |
| bus_wr | output | 1 | Forwarded store strobe |
| bus_rd | output | 1 | Forwarded load strobe |
| bus_addr | output | 32 | Forwarded address |
| exc_pulse | output | 1 | One-cycle protection exception |
| exc_kind | output | 2 | Fault kind: 0 none, 1 reserved field, 2 peripheral, 3 offset |
| exc_cause | output | 6 | Captured exception cause (0x2E after a fault) |
| exc_supv | output | 1 | Captured supervisor flag of the faulting request |
| fault_addr | output | 32 | Fault-address register |
| ret_pc | output | 32 | Return-from-exception register |

## Verification
Two functions can land on the same clock edge: a software write to the fault-address register and a fault capture. Both load the same register. The bench provokes the collision by raising sw_fa_we together with a request to a bad address. It judges the result by reading fault_addr one cycle later, which must hold the faulting address and not the software value. Back-to-back faults also exercise capture overwriting capture.

// File: rtl/mmr_fault_pkg.sv
package mmr_fault_pkg;
  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_FIELD  = 2'd1,
    FK_PERIPH = 2'd2,
    FK_OFFSET = 2'd3
  } fkind_e;

  localparam int         CAUSE_W    = 6;
  localparam logic [5:0] PROT_CAUSE = 6'h2E;
endpackage

// File: rtl/mmr_addr_decode.sv
module mmr_addr_decode
  import mmr_fault_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_LSB    = 21,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFE0_0000,
  parameter int FIELD_MSB  = 19,
  parameter int FIELD_LSB  = 16,
  parameter int PIDX_LSB   = 12,
  parameter int NUM_PERIPH = 9,
  parameter int LIM_W      = 13,
  parameter logic [NUM_PERIPH*LIM_W-1:0] LIMITS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output fkind_e            kind
);
  localparam int PIDX_W = FIELD_LSB - PIDX_LSB;
  localparam int OFS_W  = PIDX_LSB;

  logic [PIDX_W-1:0]     pidx;
  logic [OFS_W-1:0]      ofs;
  logic [NUM_PERIPH-1:0] over_lim;
  logic                  field_bad;
  logic                  pidx_bad;

  assign in_win    = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign field_bad = |addr[FIELD_MSB:FIELD_LSB];
  assign pidx      = addr[FIELD_LSB-1:PIDX_LSB];
  assign ofs       = addr[OFS_W-1:0];
  assign pidx_bad  = (int'(pidx) >= NUM_PERIPH);

  // One offset comparator per implemented peripheral
  for (genvar gi = 0; gi < NUM_PERIPH; gi++) begin : g_lim
    assign over_lim[gi] = (int'(pidx) == gi) &&
                          ({{(LIM_W-OFS_W){1'b0}}, ofs} >= LIMITS[gi*LIM_W +: LIM_W]);
  end

  // Priority: reserved field, then peripheral index, then offset
  always_comb begin
    kind = FK_NONE;
    if (in_win) begin
      if (field_bad)      kind = FK_FIELD;
      else if (pidx_bad)  kind = FK_PERIPH;
      else if (|over_lim) kind = FK_OFFSET;
    end
  end

  always_comb begin
    if (in_win && !field_bad) a_field_prio_r1 : assert (kind != FK_FIELD);
    if (in_win && field_bad)  a_field_win_r1  : assert (kind == FK_FIELD);
  end
endmodule

// File: rtl/mmr_fault_capture.sv
module mmr_fault_capture
  import mmr_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fault,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [ADDR_W-1:0]   pc_in,
  input  logic                supv_in,
  input  logic                sw_we,
  input  logic [ADDR_W-1:0]   sw_data,
  output logic [ADDR_W-1:0]   fault_addr_q,
  output logic [ADDR_W-1:0]   ret_pc_q,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic                supv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr_q <= '0;
      ret_pc_q     <= '0;
      cause_q      <= '0;
      supv_q       <= 1'b0;
    end else if (fault) begin
      fault_addr_q <= addr_in;
      ret_pc_q     <= pc_in;
      cause_q      <= PROT_CAUSE;
      supv_q       <= supv_in;
    end else if (sw_we) begin
      fault_addr_q <= sw_data;
    end
  end

  p_hold_r9 : assert property (@(posedge clk) disable iff (rst)
    (!fault && !sw_we) |=> $stable(fault_addr_q) && $stable(ret_pc_q));
  p_pc_r6 : assert property (@(posedge clk) disable iff (rst)
    fault |=> (ret_pc_q == $past(pc_in)));
  p_fault_wins_r10 : assert property (@(posedge clk) disable iff (rst)
    (fault && sw_we) |=> (fault_addr_q == $past(addr_in)));
endmodule

// File: rtl/mmr_fault_chk.sv
module mmr_fault_chk
  import mmr_fault_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_PERIPH = 9,
  parameter int LIM_W      = 13,
  parameter logic [NUM_PERIPH*LIM_W-1:0] LIMITS = {
    13'h108, 13'h204, 13'h104, 13'h010, 13'h008,
    13'h010, 13'h114, 13'h400, 13'h400}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              req_supv,
  input  logic              sw_fa_we,
  input  logic [ADDR_W-1:0] sw_fa_data,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              exc_pulse,
  output logic [1:0]        exc_kind,
  output logic [5:0]        exc_cause,
  output logic              exc_supv,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ADDR_W-1:0] ret_pc
);
  logic   in_win;
  fkind_e kind;
  logic   fault;
  logic   pass;

  mmr_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PERIPH(NUM_PERIPH), .LIM_W(LIM_W), .LIMITS(LIMITS)
  ) u_dec (
    .addr(req_addr), .in_win(in_win), .kind(kind)
  );

  assign fault = req_vld && (kind != FK_NONE);
  assign pass  = req_vld && !fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_pulse <= 1'b0;
      exc_kind  <= 2'd0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
    end else begin
      exc_pulse <= fault;
      exc_kind  <= req_vld ? kind : FK_NONE;
      bus_wr    <= pass && req_wr;
      bus_rd    <= pass && !req_wr;
      if (pass) bus_addr <= req_addr;
    end
  end

  mmr_fault_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .fault(fault),
    .addr_in(req_addr), .pc_in(req_pc), .supv_in(req_supv),
    .sw_we(sw_fa_we), .sw_data(sw_fa_data),
    .fault_addr_q(fault_addr), .ret_pc_q(ret_pc),
    .cause_q(exc_cause), .supv_q(exc_supv)
  );

  p_suppress_r7 : assert property (@(posedge clk) disable iff (rst)
    exc_pulse |-> !(bus_wr || bus_rd));
  p_outside_r8 : assert property (@(posedge clk) disable iff (rst)
    (req_vld && !in_win) |=> !exc_pulse);
  p_pulse_r4 : assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !exc_pulse);
  p_cause_r4 : assert property (@(posedge clk) disable iff (rst)
    exc_pulse |-> (exc_cause == PROT_CAUSE) && (exc_kind != 2'd0));
  p_addr_r5 : assert property (@(posedge clk) disable iff (rst)
    exc_pulse |-> (fault_addr == $past(req_addr)));
endmodule

// File: tb/mmr_fault_chk_tb.sv
module mmr_fault_chk_tb;
  localparam int CLK_PER = 10;
  localparam int NV = 22;
  // {address, expected kind}
  localparam logic [33:0] VEC [NV] = '{
    {32'hFFE80000, 2'd1}, {32'hFFE40000, 2'd1}, {32'hFFE20000, 2'd1},
    {32'hFFE10000, 2'd1}, {32'hFFE19000, 2'd1}, {32'hFFE09000, 2'd2},
    {32'hFFE0F000, 2'd2}, {32'hFFE00408, 2'd3}, {32'hFFE01408, 2'd3},
    {32'hFFE02114, 2'd3}, {32'hFFE03010, 2'd3}, {32'hFFE04008, 2'd3},
    {32'hFFE05010, 2'd3}, {32'hFFE06104, 2'd3}, {32'hFFE07204, 2'd3},
    {32'hFFE08108, 2'd3}, {32'hFFE003FC, 2'd0}, {32'hFFE08104, 2'd0},
    {32'hFFE04004, 2'd0}, {32'hFFE00000, 2'd0}, {32'h12345678, 2'd0},
    {32'hFFDFFFFC, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_vld = 1'b0, req_wr = 1'b0, req_supv = 1'b0, sw_fa_we = 1'b0;
  logic [31:0] req_addr = '0, req_pc = '0, sw_fa_data = '0;
  logic bus_wr, bus_rd, exc_pulse, exc_supv;
  logic [31:0] bus_addr, fault_addr, ret_pc;
  logic [1:0] exc_kind;
  logic [5:0] exc_cause;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_fa = '0, m_pc = '0;

  always #(CLK_PER/2) clk = ~clk;

  mmr_fault_chk u_dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_pc(req_pc), .req_supv(req_supv),
    .sw_fa_we(sw_fa_we), .sw_fa_data(sw_fa_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .exc_pulse(exc_pulse), .exc_kind(exc_kind), .exc_cause(exc_cause),
    .exc_supv(exc_supv), .fault_addr(fault_addr), .ret_pc(ret_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_vld = 1'b0; sw_fa_we = 1'b0;
  endtask

  initial begin
    #(CLK_PER*20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 exc_pulse", {31'd0, exc_pulse}, 32'd0);
    chk("R11 fault_addr", fault_addr, 32'd0);
    chk("R11 ret_pc", ret_pc, 32'd0);
    chk("R11 cause", {26'd0, exc_cause}, 32'd0);
    chk("R11 bus", {30'd0, bus_wr, bus_rd}, 32'd0);
    rst = 1'b0;

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [31:0] a;
      logic [1:0]  k;
      logic        w;
      a = VEC[i][33:2];
      k = VEC[i][1:0];
      w = i[0];
      @(negedge clk);
      req_vld = 1'b1; req_wr = w; req_addr = a;
      req_pc = 32'h1000 + 32'(i*4); req_supv = ~i[0];
      @(negedge clk);
      idle();
      if (k != 2'd0) begin m_fa = a; m_pc = 32'h1000 + 32'(i*4); end
      chk("R1/R2/R3 kind", {30'd0, exc_kind}, {30'd0, k});
      chk("R4 pulse", {31'd0, exc_pulse}, {31'd0, (k != 2'd0)});
      chk("R7 bus_wr", {31'd0, bus_wr}, {31'd0, (k == 2'd0) && w});
      chk("R7 bus_rd", {31'd0, bus_rd}, {31'd0, (k == 2'd0) && !w});
      if (k == 2'd0) chk("R7 R8 bus_addr", bus_addr, a);
      chk("R5 R9 fault_addr", fault_addr, m_fa);
      chk("R6 R9 ret_pc", ret_pc, m_pc);
      if (k != 2'd0) begin
        chk("R4 cause", {26'd0, exc_cause}, 32'h2E);
        chk("R4 supv", {31'd0, exc_supv}, {31'd0, ~i[0]});
      end
      @(negedge clk);
      chk("R4 single pulse", {31'd0, exc_pulse}, 32'd0);
    end

    // R10: software write alone
    req_vld = 1'b0; sw_fa_we = 1'b1; sw_fa_data = 32'h0;
    @(negedge clk); idle();
    chk("R10 sw write", fault_addr, 32'h0);
    chk("R9 ret_pc held", ret_pc, m_pc);

    // R10: collision, fault wins
    req_vld = 1'b1; req_wr = 1'b1; req_addr = 32'hFFE03010; req_pc = 32'h2222;
    sw_fa_we = 1'b1; sw_fa_data = 32'hCAFE0000;
    @(negedge clk); idle();
    chk("R10 fault wins", fault_addr, 32'hFFE03010);
    chk("R6 pc", ret_pc, 32'h2222);

    // Back-to-back faults: R4 R5 R6
    req_vld = 1'b1; req_addr = 32'hFFE09000; req_pc = 32'h3000;
    @(negedge clk);
    req_addr = 32'hFFE00408; req_pc = 32'h3004;
    chk("R4 b2b first", {31'd0, exc_pulse}, 32'd1);
    chk("R5 b2b first", fault_addr, 32'hFFE09000);
    @(negedge clk); idle();
    chk("R4 b2b second", {31'd0, exc_pulse}, 32'd1);
    chk("R5 b2b second", fault_addr, 32'hFFE00408);
    chk("R6 b2b second", ret_pc, 32'h3004);

    // R11: reset clears captured values
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 clear fault_addr", fault_addr, 32'd0);
    chk("R11 clear cause", {26'd0, exc_cause}, 32'd0);
    chk("R11 clear ret_pc", ret_pc, 32'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule